// File: doc/BRIEF.md
# Camera Power Mode Sequencer

This controller brings a camera's supply rails and main clock up and down in order. A power-switch level starts the sequence: the core (digital) supply enable and the main-clock select rise together, and a millisecond tick then times a configuration delay. When the delay ends, the controller pulses a single-cycle strobe that tells the image processor to load its external configuration port. While powered, a two-bit mode request picks which of the other rails are live. The sensor analog rails are enabled only for capture. The display rail is enabled in every mode but USB. The backlight follows the display rail when the panel is reported on.

When the switch drops, the controller asks the lens to stow and keeps every supply as it was. Once the stow acknowledgement arrives, it removes all enables and falls back to the subclock. If no acknowledgement comes within a timeout counted in milliseconds, it shuts down anyway and sets a fault flag that stays set until reset. All pins are plain control levels and pulses. No stream data passes through the block, so it has no handshake.

Top module: `cam_pwr_seq`

## Requirements
- R1: After reset, every output is low: all supply enables, the backlight, the main-clock select (low selects the subclock), the configuration strobe, the stow request and the fault flag.
- R2: When `pwr_sw` is seen high while off, `core_en` and `main_clk_sel` are high one cycle later. Millisecond ticks that arrive while off have no effect.
- R3: `cfg_strobe` is high for exactly one cycle. It occurs in the cycle after the CFG_DELAY_MS-th tick counted from power-on, and happens only once per power-on.
- R4: `sensor_en` is high only while powered with `mode_req` = 2 (capture). It is low for 0 (playback), 1 (LCD shooting) and 3 (USB).
- R5: `disp_en` is high while powered with `mode_req` 0, 1 or 2, and low with 3.
- R6: `bl_en` equals `disp_en` AND `lcd_on`, as both were sampled on the same edge.
- R7: A change of `mode_req` or `lcd_on` while powered updates the enables one cycle later. It does not restart the configuration delay and produces no strobe.
- R8: When `pwr_sw` is seen low while powered, `stow_req` is high the next cycle, and all enables keep their values until `lens_stowed` is seen high. One cycle after that, every enable, `main_clk_sel` and `stow_req` are low.
- R9: If STOW_TIMEOUT_MS ticks pass in the stow phase without `lens_stowed`, the controller shuts down as in R8 and sets `stow_fault`. The fault stays high until reset, through later power cycles.
- R10: If the switch drops before the configuration delay has ended, the controller goes to the stow phase and never issues that power-on's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| pwr_sw | input | 1 | Power switch level, high = on |
| mode_req | input | 2 | 0 playback, 1 LCD shooting, 2 capture, 3 USB |
| lcd_on | input | 1 | Panel is on |
| lens_stowed | input | 1 | Lens stow acknowledgement |
| core_en | output | 1 | Core/digital supply enable |
| sensor_en | output | 1 | Sensor analog supply enable |
| disp_en | output | 1 | Display supply enable |
| bl_en | output | 1 | Backlight enable |
| main_clk_sel | output | 1 | 1 = main clock, 0 = subclock |
| cfg_strobe | output | 1 | One-cycle configuration-port write strobe |
| stow_req | output | 1 | Request to stow the lens |
| stow_fault | output | 1 | Sticky stow-timeout fault |

## Verification
The bench builds the controller with CFG_DELAY_MS = 3 and STOW_TIMEOUT_MS = 4. With these values, the tick-by-tick edge of both the configuration delay and the stow timeout can be checked after every tick, not only at the end. With the phases this short, the bench can also sweep all four modes against both panel states and run several full power cycles, including an abort during the delay and a timeout followed by a clean shutdown.

// File: rtl/cam_pwr_pkg.sv
package cam_pwr_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WARM = 2'd1,
    ST_RUN  = 2'd2,
    ST_STOW = 2'd3
  } pstate_e;

  typedef enum logic [1:0] {
    MD_PLAY = 2'd0,
    MD_LCD  = 2'd1,
    MD_CAP  = 2'd2,
    MD_USB  = 2'd3
  } mode_e;
endpackage

// File: rtl/cam_ms_timer.sv
module cam_ms_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  assign done = tick && (cnt == limit - 1'b1);
endmodule

// File: rtl/cam_supply_map.sv
module cam_supply_map
  import cam_pwr_pkg::*;
(
  input  logic       live,
  input  logic [1:0] mode,
  input  logic       lcd_on,
  output logic       sens,
  output logic       disp,
  output logic       bl
);
  always_comb begin
    sens = 1'b0;
    disp = 1'b0;
    if (live) begin
      case (mode_e'(mode))
        MD_CAP:  begin sens = 1'b1; disp = 1'b1; end
        MD_PLAY,
        MD_LCD:  disp = 1'b1;
        default: disp = 1'b0;
      endcase
    end
    bl = disp && lcd_on;
  end
endmodule

// File: rtl/cam_pwr_seq.sv
module cam_pwr_seq
  import cam_pwr_pkg::*;
#(
  parameter int CFG_DELAY_MS    = 100,
  parameter int STOW_TIMEOUT_MS = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       pwr_sw,
  input  logic [1:0] mode_req,
  input  logic       lcd_on,
  input  logic       lens_stowed,
  output logic       core_en,
  output logic       sensor_en,
  output logic       disp_en,
  output logic       bl_en,
  output logic       main_clk_sel,
  output logic       cfg_strobe,
  output logic       stow_req,
  output logic       stow_fault
);
  localparam int MAXL = (CFG_DELAY_MS > STOW_TIMEOUT_MS) ? CFG_DELAY_MS : STOW_TIMEOUT_MS;
  localparam int CW   = $clog2(MAXL + 1);

  pstate_e st, st_n;
  logic [CW-1:0] lim;
  logic tmr_done, live_n, sens_n, disp_n, bl_n, strobe_n, fault_n;

  assign lim = (st == ST_WARM) ? CW'(CFG_DELAY_MS) : CW'(STOW_TIMEOUT_MS);

  cam_ms_timer #(.CW(CW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_n != st),
    .tick  (ms_tick),
    .limit (lim),
    .done  (tmr_done)
  );

  always_comb begin
    st_n = st;
    case (st)
      ST_OFF:  if (pwr_sw) st_n = ST_WARM;
      ST_WARM: if (!pwr_sw) st_n = ST_STOW;
               else if (tmr_done) st_n = ST_RUN;
      ST_RUN:  if (!pwr_sw) st_n = ST_STOW;
      ST_STOW: if (lens_stowed || tmr_done) st_n = ST_OFF;
      default: st_n = ST_OFF;
    endcase
  end

  assign live_n   = (st_n != ST_OFF);
  assign strobe_n = (st == ST_WARM) && pwr_sw && tmr_done;
  assign fault_n  = (st == ST_STOW) && !lens_stowed && tmr_done;

  cam_supply_map u_map (
    .live   (live_n),
    .mode   (mode_req),
    .lcd_on (lcd_on),
    .sens   (sens_n),
    .disp   (disp_n),
    .bl     (bl_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_OFF;
      core_en      <= 1'b0;
      sensor_en    <= 1'b0;
      disp_en      <= 1'b0;
      bl_en        <= 1'b0;
      main_clk_sel <= 1'b0;
      cfg_strobe   <= 1'b0;
      stow_req     <= 1'b0;
      stow_fault   <= 1'b0;
    end else begin
      st           <= st_n;
      core_en      <= live_n;
      main_clk_sel <= live_n;
      sensor_en    <= sens_n;
      disp_en      <= disp_n;
      bl_en        <= bl_n;
      cfg_strobe   <= strobe_n;
      stow_req     <= (st_n == ST_STOW);
      if (fault_n) stow_fault <= 1'b1;
    end
  end
endmodule

// File: rtl/cam_pwr_seq_chk.sv
module cam_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_req,
  input logic       lcd_on,
  input logic       core_en,
  input logic       sensor_en,
  input logic       disp_en,
  input logic       bl_en,
  input logic       cfg_strobe,
  input logic       stow_req,
  input logic       stow_fault
);
  assert_sensor_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sensor_en) |-> ($past(mode_req) == 2'd2 && core_en));

  assert_display_not_usb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_en) |-> ($past(mode_req) != 2'd3));

  assert_backlight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bl_en |-> (disp_en && $past(lcd_on)));

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_strobe |=> !cfg_strobe);

  assert_stow_before_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_en) |-> $past(stow_req));

  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stow_fault |=> stow_fault);
endmodule

bind cam_pwr_seq cam_pwr_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_req   (mode_req),
  .lcd_on     (lcd_on),
  .core_en    (core_en),
  .sensor_en  (sensor_en),
  .disp_en    (disp_en),
  .bl_en      (bl_en),
  .cfg_strobe (cfg_strobe),
  .stow_req   (stow_req),
  .stow_fault (stow_fault)
);

// File: tb/sim_cam_pwr_seq.sv
module sim_cam_pwr_seq;
  localparam int CLK_PER = 10;
  localparam int CFG     = 3;
  localparam int TMO     = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ms_tick = 1'b0, pwr_sw = 1'b0, lcd_on = 1'b0, lens_stowed = 1'b0;
  logic [1:0] mode_req = 2'd0;
  logic core_en, sensor_en, disp_en, bl_en, main_clk_sel, cfg_strobe, stow_req, stow_fault;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  cam_pwr_seq #(.CFG_DELAY_MS(CFG), .STOW_TIMEOUT_MS(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pwr_sw(pwr_sw),
    .mode_req(mode_req), .lcd_on(lcd_on), .lens_stowed(lens_stowed),
    .core_en(core_en), .sensor_en(sensor_en), .disp_en(disp_en), .bl_en(bl_en),
    .main_clk_sel(main_clk_sel), .cfg_strobe(cfg_strobe), .stow_req(stow_req),
    .stow_fault(stow_fault));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {core_en, sensor_en, disp_en, bl_en, main_clk_sel, cfg_strobe, stow_req, stow_fault};
  endfunction

  // one cycle: apply tick (or not) at a negedge, sample at the following negedge
  task automatic step(input logic tk);
    ms_tick = tk;
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  task automatic power_on_to_run(input logic flt);
    pwr_sw = 1'b1;
    step(1'b0);
    chk("R2 core/clk up", {core_en, main_clk_sel, cfg_strobe}, 8'b110);
    for (int i = 0; i < CFG; i++) begin
      step(1'b1);
      chk("R3 strobe timing", {7'd0, cfg_strobe}, {7'd0, logic'(i == CFG-1)});
    end
    step(1'b0);
    chk("R3 strobe one cycle", {7'd0, cfg_strobe}, 8'd0);
    chk("R9 fault kept", {7'd0, stow_fault}, {7'd0, flt});
  endtask

  task automatic stow_ack(input logic flt);
    lens_stowed = 1'b1;
    step(1'b0);
    lens_stowed = 1'b0;
    chk("R8 all low after ack", outs(), {7'd0, flt});
  endtask

  initial begin
    #(CLK_PER * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", outs(), 8'd0);
    rst_n = 1'b1;
    step(1'b1); step(1'b1);
    chk("R2 ticks ignored while off", outs(), 8'd0);

    // R2/R3 power-on in playback with panel on
    mode_req = 2'd0; lcd_on = 1'b1;
    power_on_to_run(1'b0);

    // R4 R5 R6 R7 sweep of modes and panel state while running
    for (int m = 0; m < 4; m++) begin
      for (int l = 0; l < 2; l++) begin
        logic ed;
        mode_req = 2'(m); lcd_on = logic'(l);
        ed = (m != 3);
        step(1'b0);
        chk("R4 sensor by mode", {7'd0, sensor_en}, {7'd0, logic'(m == 2)});
        chk("R5 display by mode", {7'd0, disp_en}, {7'd0, ed});
        chk("R6 backlight", {7'd0, bl_en}, {7'd0, logic'(ed && (l == 1))});
        chk("R7 no strobe on mode change", {6'd0, core_en, cfg_strobe}, 8'b10);
      end
    end

    // R8 shutdown with acknowledgement in capture mode
    mode_req = 2'd2; lcd_on = 1'b1;
    step(1'b0);
    pwr_sw = 1'b0;
    step(1'b0);
    chk("R8 stow requested, supplies held", outs(), 8'b11111010);
    step(1'b1); step(1'b1);
    chk("R8 held before ack", outs(), 8'b11111010);
    stow_ack(1'b0);

    // R10 abort during configuration delay
    mode_req = 2'd1;
    pwr_sw = 1'b1;
    step(1'b0);
    step(1'b1);
    pwr_sw = 1'b0;
    step(1'b1);
    chk("R10 abort to stow", {6'd0, cfg_strobe, stow_req}, 8'b01);
    for (int i = 0; i < 2; i++) begin
      step(1'b1);
      chk("R10 no strobe after abort", {7'd0, cfg_strobe}, 8'd0);
    end
    stow_ack(1'b0);

    // R9 stow timeout
    mode_req = 2'd3; lcd_on = 1'b0;
    power_on_to_run(1'b0);
    pwr_sw = 1'b0;
    step(1'b0);
    for (int i = 0; i < TMO; i++) begin
      step(1'b1);
      chk("R9 timeout edge core_en", {7'd0, core_en}, {7'd0, logic'(i != TMO-1)});
      chk("R9 timeout edge fault", {7'd0, stow_fault}, {7'd0, logic'(i == TMO-1)});
    end
    chk("R9 forced off state", outs(), 8'b00000001);

    // R9 fault stays through a clean power cycle
    mode_req = 2'd2;
    power_on_to_run(1'b1);
    pwr_sw = 1'b0;
    step(1'b0);
    stow_ack(1'b1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule